// File: doc/BRIEF.md
# Programmable 8-bit Interval and Event Timer

This block counts events or clock periods from one of three sources and reports each time a programmed interval ends. The sources are a key input from outside the chip, a slow oscillator clock and a fast oscillator clock. All three arrive as raw levels. The block resynchronises them into its single system clock and turns the chosen one into one-cycle count events.

The key input can pass through a debounce filter, which is paced by a slow tick the chip supplies. A second mode takes the input straight through instead. The chosen events feed a predivider with four ratios, and the predivider steps an 8-bit down counter. When the counter steps past zero, it reloads from the reload value and raises a one-cycle underflow pulse.

Software sets the reload value, the ratio and the source. It then strobes the counter reset and sets the run bit.

Top module: `timer8_prog`

## Requirements
- R1: After reset, `count_val` is 0x00 and `underflow` is 0.
- R2: A one-cycle `ctr_reset` strobe loads `reload_data` into the counter on the next clock and clears the predivider, so that a full ratio of new events is needed before the next step.
- R3: `div_sel` sets the number of source events per counter step: 2'b00 gives 256, 2'b01 gives 32, 2'b10 gives 4 and 2'b11 gives 1.
- R4: Each predivider output lowers `count_val` by exactly one.
- R5: A step taken while `count_val` is 0x00 reloads `reload_data` and raises `underflow` for exactly one clock cycle.
- R6: While `run` is 0, source events are ignored, and both the predivider and the counter hold their values. When `run` returns to 1, counting resumes from the held predivider state.
- R7: `src_sel` chooses the source: 2'b00 is the key input, 2'b01 the slow clock, 2'b10 the fast clock and 2'b11 none. With the key input as source, only falling edges count.
- R8: With either oscillator as source, only rising edges count.
- R9: The fast clock produces counts only while `fast_osc_en` is 1.
- R10: With `direct_mode` at 0, a key level change takes effect only after it has held through `FILT_TICKS` (default 4) consecutive `filt_tick` pulses. A low pulse spanning 2 ticks causes no count. A low pulse spanning 6 ticks causes exactly one count.
- R11: With `direct_mode` at 1, the filter is bypassed, and a key low pulse of a few system clocks counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 1 | Raw external key input, idle high |
| slow_clk_in | input | 1 | Raw slow oscillator clock level |
| fast_clk_in | input | 1 | Raw fast oscillator clock level |
| fast_osc_en | input | 1 | Fast oscillator running |
| filt_tick | input | 1 | Slow one-cycle tick pacing the key filter |
| reload_data | input | 8 | Reload value for the counter |
| div_sel | input | 2 | Predivider ratio code |
| src_sel | input | 2 | Count source code |
| direct_mode | input | 1 | 1 bypasses the key filter |
| ctr_reset | input | 1 | Strobe: load counter, clear predivider |
| run | input | 1 | 1 counts, 0 holds |
| count_val | output | 8 | Current counter value |
| underflow | output | 1 | One-cycle pulse when the counter wraps |

## Verification
The hardest cases to reach from the ports lie in the key filter. Two things must be shown there: a rejected glitch leaves the hidden debounce count with no lasting effect, and an accepted pulse yields exactly one count. The bench drives `filt_tick` itself at a fixed spacing, so it knows how many ticks each low pulse spans. It first sends a two-tick glitch, then a six-tick pulse, and reads the counter after each. A related case is predivider state that survives a stop. The bench reaches it by pausing `run` partway through a ratio and then counting the events still needed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_KEY  = 2'b00,
    SRC_SLOW = 2'b01,
    SRC_FAST = 2'b10,
    SRC_NONE = 2'b11
  } src_sel_e;

  localparam int NUM_SRC  = 3;
  localparam int IDX_KEY  = 0;
  localparam int IDX_SLOW = 1;
  localparam int IDX_FAST = 2;

  // log2 of the predivider ratio for each select code (R3)
  function automatic int div_log2(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 5;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/tmr_filter.sv
module tmr_filter #(
  parameter int   THRESH  = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);

  localparam int CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == CW'(THRESH - 1)) begin
        lvl_d = raw;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= RST_LVL;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int   FALL    = 0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  if (FALL != 0) begin : g_fall
    assign pulse = prev_q & ~lvl;
  end else begin : g_rise
    assign pulse = ~prev_q & lvl;
  end

endmodule

// File: rtl/tmr_prediv.sv
module tmr_prediv #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [PW-1:0] mask,
  output logic          tick
);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = step & ~clr & ((cnt_q & mask) == mask);

endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] reload,
  output logic [W-1:0] value,
  output logic         uf
);

  logic [W-1:0] val_q, val_d;
  logic         uf_q, uf_d;
  logic         at_zero;

  assign at_zero = (val_q == '0);

  always_comb begin
    val_d = val_q;
    uf_d  = 1'b0;
    if (load) begin
      val_d = reload;
    end else if (dec) begin
      if (at_zero) begin
        val_d = reload;
        uf_d  = 1'b1;
      end else begin
        val_d = val_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      val_q <= val_d;
      uf_q  <= uf_d;
    end
  end

  assign value = val_q;
  assign uf    = uf_q;

endmodule

// File: rtl/timer8_prog.sv
module timer8_prog
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 8,
  parameter int FILT_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_in,
  input  logic             slow_clk_in,
  input  logic             fast_clk_in,
  input  logic             fast_osc_en,
  input  logic             filt_tick,
  input  logic [CNT_W-1:0] reload_data,
  input  logic [1:0]       div_sel,
  input  logic [1:0]       src_sel,
  input  logic             direct_mode,
  input  logic             ctr_reset,
  input  logic             run,
  output logic [CNT_W-1:0] count_val,
  output logic             underflow
);

  localparam logic [NUM_SRC-1:0] SYNC_RST = NUM_SRC'(1) << IDX_KEY;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  // resynchronise raw sources
  logic [NUM_SRC-1:0] raw_lvl, sync_lvl, src_lvl, src_edge;
  assign raw_lvl[IDX_KEY]  = key_in;
  assign raw_lvl[IDX_SLOW] = slow_clk_in;
  assign raw_lvl[IDX_FAST] = fast_clk_in;

  tmr_sync #(.W(NUM_SRC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw_lvl), .q(sync_lvl)
  );

  // key debounce
  logic key_filt;
  tmr_filter #(.THRESH(FILT_TICKS), .RST_LVL(1'b1)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .tick(filt_tick),
    .raw(sync_lvl[IDX_KEY]), .level(key_filt)
  );

  assign src_lvl[IDX_KEY]  = direct_mode ? sync_lvl[IDX_KEY] : key_filt;
  assign src_lvl[IDX_SLOW] = sync_lvl[IDX_SLOW];
  assign src_lvl[IDX_FAST] = sync_lvl[IDX_FAST];

  // key counts on falling edges, oscillators on rising edges
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    localparam int   IS_KEY = (i == IDX_KEY) ? 1 : 0;
    localparam logic PRV0   = (i == IDX_KEY) ? 1'b1 : 1'b0;
    tmr_edge #(.FALL(IS_KEY), .RST_VAL(PRV0)) u_edge (
      .clk(clk), .rst_n(rst_int_n), .lvl(src_lvl[i]), .pulse(src_edge[i])
    );
  end

  // source select
  logic src_evt;
  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_KEY:  src_evt = src_edge[IDX_KEY];
      SRC_SLOW: src_evt = src_edge[IDX_SLOW];
      SRC_FAST: src_evt = src_edge[IDX_FAST] & fast_osc_en;
      default:  src_evt = 1'b0;
    endcase
  end

  // predivider
  logic [PRE_W-1:0] div_mask;
  logic             pre_step, pre_tick;

  always_comb begin
    div_mask = PRE_W'((32'd1 << div_log2(div_sel)) - 32'd1);
  end

  assign pre_step = src_evt & run;

  tmr_prediv #(.PW(PRE_W)) u_prediv (
    .clk(clk), .rst_n(rst_int_n), .clr(ctr_reset), .step(pre_step),
    .mask(div_mask), .tick(pre_tick)
  );

  // down counter
  tmr_downcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(ctr_reset), .dec(pre_tick),
    .reload(reload_data), .value(count_val), .uf(underflow)
  );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ctr_reset,
  input logic [CNT_W-1:0] reload_data,
  input logic [CNT_W-1:0] count_val,
  input logic             underflow
);

  assert_reset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_reset |=> (count_val == $past(reload_data)));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctr_reset) |=> ($stable(count_val) && !underflow));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctr_reset) |=> ((count_val == $past(count_val)) ||
                             (count_val == CNT_W'($past(count_val) - 1'b1)) ||
                             ($past(count_val) == '0 && count_val == $past(reload_data))));

  assert_uf_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> ($past(count_val) == '0 && count_val == $past(reload_data)));

  assert_uf_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);

endmodule

bind timer8_prog tmr_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_timer8_prog.sv
module sim_timer8_prog;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_in, slow_clk_in, fast_clk_in, fast_osc_en, filt_tick;
  logic [7:0] reload_data;
  logic [1:0] div_sel, src_sel;
  logic       direct_mode, ctr_reset, run;
  logic [7:0] count_val;
  logic       underflow;

  int n_tests = 0;
  int n_fail  = 0;
  int uf_cnt  = 0;
  int uf_wide = 0;
  logic uf_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer8_prog u0 (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .slow_clk_in(slow_clk_in),
    .fast_clk_in(fast_clk_in), .fast_osc_en(fast_osc_en), .filt_tick(filt_tick),
    .reload_data(reload_data), .div_sel(div_sel), .src_sel(src_sel),
    .direct_mode(direct_mode), .ctr_reset(ctr_reset), .run(run),
    .count_val(count_val), .underflow(underflow)
  );

  // filter tick generator
  initial begin
    int k = 0;
    filt_tick = 1'b0;
    forever begin
      @(negedge clk);
      filt_tick = (k % TICK_DIV == TICK_DIV - 1);
      k++;
    end
  end

  // underflow pulse monitor
  always @(negedge clk) begin
    if (underflow) uf_cnt++;
    if (underflow && uf_prev) uf_wide++;
    uf_prev <= underflow;
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_slow(int n);
    for (int i = 0; i < n; i++) begin
      slow_clk_in = 1'b1; cyc(3);
      slow_clk_in = 1'b0; cyc(3);
    end
  endtask

  task automatic pulse_fast(int n);
    for (int i = 0; i < n; i++) begin
      fast_clk_in = 1'b1; cyc(3);
      fast_clk_in = 1'b0; cyc(3);
    end
  endtask

  task automatic setup(logic [1:0] src, logic [1:0] dv, logic [7:0] rl);
    run = 1'b0; src_sel = src; div_sel = dv; reload_data = rl;
    cyc(4);
    ctr_reset = 1'b1; cyc(1); ctr_reset = 1'b0;
    run = 1'b1; cyc(1);
  endtask

  task automatic t_reset;
    check("R1", "count after reset", count_val, 0);
    check("R1", "underflow after reset", underflow, 0);
  endtask

  task automatic t_load;
    setup(2'b01, 2'b11, 8'h5A);
    check("R2", "loaded value", count_val, 8'h5A);
    pulse_slow(3); cyc(4);
    check("R4", "three steps at 1/1 (R8 rising)", count_val, 8'h57);
  endtask

  task automatic t_ratio(logic [1:0] dv, int ratio);
    setup(2'b01, dv, 8'h80);
    pulse_slow(ratio - 1); cyc(4);
    check("R3", $sformatf("no step before ratio %0d", ratio), count_val, 8'h80);
    pulse_slow(1); cyc(4);
    check("R3", $sformatf("one step at ratio %0d", ratio), count_val, 8'h7F);
  endtask

  task automatic t_prediv_clear;
    setup(2'b01, 2'b10, 8'h30);
    pulse_slow(3);
    ctr_reset = 1'b1; cyc(1); ctr_reset = 1'b0;
    pulse_slow(3); cyc(4);
    check("R2", "predivider cleared by reset strobe", count_val, 8'h30);
    pulse_slow(1); cyc(4);
    check("R2", "step after full ratio", count_val, 8'h2F);
  endtask

  task automatic t_stop;
    setup(2'b01, 2'b10, 8'h40);
    pulse_slow(2);
    run = 1'b0;
    pulse_slow(5); cyc(4);
    check("R6", "held while stopped", count_val, 8'h40);
    run = 1'b1;
    pulse_slow(1); cyc(4);
    check("R6", "predivider kept (3 of 4)", count_val, 8'h40);
    pulse_slow(1); cyc(4);
    check("R6", "step on 4th counted event", count_val, 8'h3F);
  endtask

  task automatic t_underflow;
    int uf0;
    setup(2'b01, 2'b11, 8'h02);
    uf0 = uf_cnt;
    pulse_slow(2); cyc(4);
    check("R4", "counted down to zero", count_val, 0);
    check("R5", "no underflow before wrap", uf_cnt - uf0, 0);
    pulse_slow(1); cyc(4);
    check("R5", "reloaded after zero", count_val, 2);
    check("R5", "one underflow pulse", uf_cnt - uf0, 1);
    check("R5", "underflow width one cycle", uf_wide, 0);
  endtask

  task automatic t_fast;
    setup(2'b10, 2'b11, 8'h10);
    fast_osc_en = 1'b0;
    pulse_fast(3); cyc(4);
    check("R9", "fast disabled gives no counts", count_val, 8'h10);
    fast_osc_en = 1'b1;
    pulse_fast(3); cyc(4);
    check("R9", "fast enabled counts", count_val, 8'h0D);
    pulse_slow(2); cyc(4);
    check("R8", "slow ignored with fast selected", count_val, 8'h0D);
  endtask

  task automatic t_none;
    setup(2'b11, 2'b11, 8'h22);
    pulse_slow(2); pulse_fast(2);
    key_in = 1'b0; cyc(6); key_in = 1'b1; cyc(6);
    check("R7", "no source selected", count_val, 8'h22);
  endtask

  task automatic t_key_direct;
    direct_mode = 1'b1;
    setup(2'b00, 2'b11, 8'h50);
    key_in = 1'b0; cyc(6);
    check("R11", "falling edge counts (direct)", count_val, 8'h4F);
    key_in = 1'b1; cyc(6);
    check("R7", "rising edge ignored", count_val, 8'h4F);
    pulse_slow(2); cyc(4);
    check("R7", "slow ignored with key selected", count_val, 8'h4F);
  endtask

  task automatic t_key_filter;
    direct_mode = 1'b0;
    setup(2'b00, 2'b11, 8'h50);
    key_in = 1'b0; cyc(2 * TICK_DIV);
    key_in = 1'b1; cyc(6 * TICK_DIV);
    check("R10", "2-tick glitch rejected", count_val, 8'h50);
    key_in = 1'b0; cyc(6 * TICK_DIV);
    check("R10", "6-tick low accepted", count_val, 8'h4F);
    key_in = 1'b1; cyc(6 * TICK_DIV);
    check("R10", "release gives no extra count", count_val, 8'h4F);
    key_in = 1'b0; cyc(4); key_in = 1'b1; cyc(6 * TICK_DIV);
    check("R10", "short pulse rejected when filtered", count_val, 8'h4F);
  endtask

  initial begin
    rst_n = 1'b0;
    key_in = 1'b1; slow_clk_in = 1'b0; fast_clk_in = 1'b0; fast_osc_en = 1'b0;
    reload_data = 8'h00; div_sel = 2'b11; src_sel = 2'b01;
    direct_mode = 1'b0; ctr_reset = 1'b0; run = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_load();
    t_ratio(2'b11, 1);
    t_ratio(2'b10, 4);
    t_ratio(2'b01, 32);
    t_ratio(2'b00, 256);
    t_prediv_clear();
    t_stop();
    t_underflow();
    t_fast();
    t_none();
    t_key_direct();
    t_key_filter();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule